// File: doc/BRIEF.md
# Multiply, Accumulate and Divide Register Unit

This block is an unsigned arithmetic helper for a 16-bit microcontroller bus. Software reaches it through one synchronous register port: an address, a write strobe, a 16-bit write bus and a registered 16-bit read bus. Three 32-bit register pairs (A, B and C) and a control byte are mapped on the port. The control byte selects one of three modes: plain multiply, multiply-accumulate or division.

In the two multiply modes, a write to the high half of A starts a 16x16 product of the two halves of A. The product lands in B. In accumulate mode the product is also added to C one cycle later. Software may preload C before it starts. In divide mode, A holds the dividend and B the divisor. A control write with the start bit set runs a two-bits-per-cycle restoring divider for 16 cycles. During that time the start bit reads back as busy. When the divider finishes, the quotient overwrites A and the remainder goes to C. An optional one-cycle interrupt pulse marks the end of a division.

Top module: `arith_mdu`

## Requirements
- R1: After a synchronous reset, every register reads zero, `rdata` is zero and `irq` is low.
- R2: The address presented in a cycle selects the value that appears on `rdata` after that cycle's clock edge. The map is: 0 A-low, 1 A-high, 2 B-low, 3 B-high, 4 C-low, 5 C-high, 6 control, 7 zero. The control register reads mode bits 7:6 as written and bit 0 as the busy flag. Its other bits read zero.
- R3: With control mode 0x00, a write to A-high in cycle k loads B-high:B-low with the 32-bit unsigned product A-low × A-high at the edge that ends cycle k+1.
- R4: With control mode 0x40 (bit 6 set, bit 7 clear), each write to A-high also loads the product into B. The same product is added, modulo 2^32, to C-high:C-low at the edge that ends cycle k+2. Writes to A-high in back-to-back cycles each add their own product.
- R5: Writes to C-low and C-high load the accumulator directly, so a multiply-accumulate run can start from any value.
- R6: A control write with bit 7 and bit 0 set (for example 0xC1) starts a division of A-high:A-low by B-high:B-low. Control bit 0 then reads 1 for exactly 16 cycles and clears itself.
- R7: At the end of a division, A holds the quotient, C holds the remainder and B still holds the divisor.
- R8: A division by zero also takes 16 cycles. It returns the quotient 0xFFFFFFFF and leaves the dividend as the remainder.
- R9: Writes to A, B, C or the control register are ignored while a division is busy.
- R10: A division started with bit 6 clear (0x81) raises `irq` for exactly one cycle, right after busy clears. A division started with 0xC1 raises no interrupt, and neither do the multiply modes.
- R11: In divide mode, a write to A-high stores the value but starts no multiply, so B is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register select for both read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data of the register addressed in the previous cycle |
| irq | output | 1 | One-cycle pulse at the end of a division when bit 6 is clear |

## Verification
The hardest case is register traffic that arrives while the divider is running. Such writes must leave the final quotient, remainder and divisor untouched, and a control write must neither restart the divider nor change the mode. The stimulus reaches this case by starting a division and then writing to A, B, C and the control register in the cycles that follow. Only after busy has cleared does it read the results back. A second hard case is the exact pipeline timing. The bench reads B and C in the cycle the update is due and in the cycle before it, and polls the busy bit every cycle of each division so that the busy count and the interrupt cycle are both observed.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    RS_ALO = 3'd0,
    RS_AHI = 3'd1,
    RS_BLO = 3'd2,
    RS_BHI = 3'd3,
    RS_CLO = 3'd4,
    RS_CHI = 3'd5,
    RS_CTL = 3'd6,
    RS_NUL = 3'd7
  } reg_sel_e;

  localparam int CB_DIV = 7;  // divide-mode select
  localparam int CB_MAC = 6;  // accumulate select / interrupt mask in divide mode
  localparam int CB_GO  = 0;  // divide start, reads as busy
endpackage

// File: rtl/mdu_mult.sv
module mdu_mult #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            mac_in,
  input  logic [DW-1:0]   opa,
  input  logic [DW-1:0]   opb,
  output logic [2*DW-1:0] prod_q,
  output logic            vld_q,
  output logic            mac_q
);
  localparam int PW = 2 * DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      vld_q  <= 1'b0;
      mac_q  <= 1'b0;
    end else begin
      vld_q <= go;
      mac_q <= go && mac_in;
      if (go) prod_q <= PW'(opa) * PW'(opb);
    end
  end
endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W    = 32,
  parameter int STEP = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quo_nxt,
  output logic [W-1:0] rem_nxt
);
  localparam int ITER = W / STEP;
  localparam int CW   = (ITER > 1) ? $clog2(ITER) : 1;

  logic [CW-1:0] cnt;
  logic [W-1:0]  quo_q, rem_q, den_q;
  logic [W-1:0]  rs [STEP+1];
  logic [W-1:0]  qs [STEP+1];

  assign rs[0] = rem_q;
  assign qs[0] = quo_q;

  for (genvar g = 0; g < STEP; g++) begin : g_step
    logic [W:0] sh;
    logic       ge;
    assign sh        = {rs[g], qs[g][W-1]};
    assign ge        = (sh >= {1'b0, den_q});
    assign rs[g+1]   = ge ? W'(sh - {1'b0, den_q}) : sh[W-1:0];
    assign qs[g+1]   = {qs[g][W-2:0], ge};
  end

  assign fin     = busy && (cnt == CW'(ITER - 1));
  assign quo_nxt = qs[STEP];
  assign rem_nxt = rs[STEP];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      quo_q <= '0;
      rem_q <= '0;
      den_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt   <= '0;
      quo_q <= dividend;
      rem_q <= '0;
      den_q <= divisor;
    end else if (busy) begin
      quo_q <= qs[STEP];
      rem_q <= rs[STEP];
      cnt   <= cnt + 1'b1;
      if (fin) busy <= 1'b0;
    end
  end

  // R6: busy stays up until the final iteration
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |=> busy);
  // R6: busy drops right after the final iteration
  a_r6_busy_clears: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy);
  // R8: a zero divisor yields an all-ones quotient
  a_r8_divzero_ones: assert property (@(posedge clk) disable iff (rst)
    (fin && den_q == '0) |-> (&quo_nxt));
endmodule

// File: rtl/arith_mdu.sv
module arith_mdu
  import mdu_pkg::*;
#(
  parameter int DW         = 16,
  parameter int RADIX_BITS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int PW = 2 * DW;

  logic [DW-1:0] a_lo, a_hi, b_lo, b_hi, c_lo, c_hi;
  logic [1:0]    mode;          // [1] divide, [0] accumulate / irq mask
  logic          busy, fin;
  logic [PW-1:0] quo_nxt, rem_nxt;
  logic [PW-1:0] prod_q, addend;
  logic          mul_vld, mul_mac, acc_pend;
  logic          wr_ok, start, go;
  logic [DW-1:0] rd_mux;

  assign wr_ok = wr_en && !busy;
  assign start = wr_ok && (addr == RS_CTL) && wdata[CB_DIV] && wdata[CB_GO];
  assign go    = wr_ok && (addr == RS_AHI) && !mode[1];

  mdu_mult #(.DW(DW)) u_mul (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .mac_in (mode[0]),
    .opa    (a_lo),
    .opb    (wdata),
    .prod_q (prod_q),
    .vld_q  (mul_vld),
    .mac_q  (mul_mac)
  );

  mdu_div #(.W(PW), .STEP(RADIX_BITS)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .dividend ({a_hi, a_lo}),
    .divisor  ({b_hi, b_lo}),
    .busy     (busy),
    .fin      (fin),
    .quo_nxt  (quo_nxt),
    .rem_nxt  (rem_nxt)
  );

  always_comb begin
    case (addr)
      RS_ALO:  rd_mux = a_lo;
      RS_AHI:  rd_mux = a_hi;
      RS_BLO:  rd_mux = b_lo;
      RS_BHI:  rd_mux = b_hi;
      RS_CLO:  rd_mux = c_lo;
      RS_CHI:  rd_mux = c_hi;
      RS_CTL:  rd_mux = {{(DW-8){1'b0}}, mode, 5'b0, busy};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_lo <= '0; a_hi <= '0;
      b_lo <= '0; b_hi <= '0;
      c_lo <= '0; c_hi <= '0;
      mode     <= '0;
      acc_pend <= 1'b0;
      addend   <= '0;
      irq      <= 1'b0;
      rdata    <= '0;
    end else begin
      // operand A: quotient on completion, otherwise software
      if (fin) {a_hi, a_lo} <= quo_nxt;
      else if (wr_ok && addr == RS_ALO) a_lo <= wdata;
      else if (wr_ok && addr == RS_AHI) a_hi <= wdata;

      // B: product has priority over software
      if (mul_vld) {b_hi, b_lo} <= prod_q;
      else if (wr_ok && addr == RS_BLO) b_lo <= wdata;
      else if (wr_ok && addr == RS_BHI) b_hi <= wdata;

      // C: remainder, then software preload, then accumulation
      if (fin) {c_hi, c_lo} <= rem_nxt;
      else if (wr_ok && addr == RS_CLO) c_lo <= wdata;
      else if (wr_ok && addr == RS_CHI) c_hi <= wdata;
      else if (acc_pend) {c_hi, c_lo} <= {c_hi, c_lo} + addend;

      acc_pend <= mul_vld && mul_mac;
      if (mul_vld) addend <= prod_q;

      if (wr_ok && addr == RS_CTL) mode <= {wdata[CB_DIV], wdata[CB_MAC]};

      irq   <= fin && !mode[0];
      rdata <= rd_mux;
    end
  end

  // R9: B never moves while the divider runs
  a_r9_b_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |=> $stable({b_hi, b_lo}));
  // R10: the interrupt only fires in unmasked divide mode
  a_r10_irq_mode: assert property (@(posedge clk) disable iff (rst)
    irq |-> (mode == 2'b10));
  // R10: the interrupt follows the last divider iteration
  a_r10_irq_after_fin: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(fin));
  // R11: no multiply result after an A-high write in divide mode
  a_r11_no_mul_in_div: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == RS_AHI && mode[1]) |=> !mul_vld);
endmodule

// File: tb/arith_mdu_test.sv
`timescale 1ns/1ps
module arith_mdu_test;
  localparam logic [2:0] ALO = 3'd0, AHI = 3'd1, BLO = 3'd2, BHI = 3'd3;
  localparam logic [2:0] CLO = 3'd4, CHI = 3'd5, CTL = 3'd6, NUL = 3'd7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  arith_mdu uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] exp_quo(input logic [31:0] n, input logic [31:0] d);
    return (d == 0) ? 32'hFFFF_FFFF : n / d;
  endfunction

  function automatic logic [31:0] exp_rem(input logic [31:0] n, input logic [31:0] d);
    return (d == 0) ? n : n % d;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  // one bus cycle; returns at the next falling edge
  task automatic put(input logic w, input logic [2:0] a, input logic [15:0] d);
    wr_en = w; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd32(input logic [2:0] lo, output logic [31:0] v);
    put(1'b0, lo, 16'h0);
    v[15:0] = rdata;
    put(1'b0, lo + 3'd1, 16'h0);
    v[31:16] = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b0, NUL, 16'h0);
  endtask

  task automatic run_div(input logic [31:0] n, input logic [31:0] d,
                         input logic [7:0] cv, input string tag);
    int ones, irqs;
    logic [31:0] v;
    put(1'b1, CTL, cv & 8'hFE);
    put(1'b1, ALO, n[15:0]);  put(1'b1, AHI, n[31:16]);
    put(1'b1, BLO, d[15:0]);  put(1'b1, BHI, d[31:16]);
    put(1'b1, CTL, cv | 8'h01);
    ones = 0; irqs = 0;
    for (int i = 0; i < 20; i++) begin
      put(1'b0, CTL, 16'h0);
      if (rdata[0]) ones++;
      if (irq) irqs++;
    end
    check({"R6 busy cycles ", tag}, ones, 16);
    check({"R10 irq pulses ", tag}, irqs, cv[6] ? 0 : 1);
    rd32(ALO, v);
    check({(d == 0) ? "R8 quotient " : "R7 quotient ", tag}, v, exp_quo(n, d));
    rd32(CLO, v);
    check({(d == 0) ? "R8 remainder " : "R7 remainder ", tag}, v, exp_rem(n, d));
    rd32(BLO, v);
    check({"R7 divisor kept ", tag}, v, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v, acc, oldb, n, d;
    logic [15:0] a, b, b2;
    void'($urandom(32'h5EED));

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 irq low", irq, 0);
    check("R1 rdata zero", rdata, 0);
    for (int r = 0; r < 8; r++) begin
      put(1'b0, 3'(r), 16'h0);
      check("R1 register zero", rdata, 0);
    end

    // R2 map and control masking
    put(1'b1, ALO, 16'h1234);
    put(1'b0, ALO, 16'h0);
    check("R2 A-low readback", rdata, 16'h1234);
    put(1'b1, CTL, 16'hFF7E);
    put(1'b0, CTL, 16'h0);
    check("R2 control masked", rdata, 16'h0040);
    put(1'b0, NUL, 16'h0);
    check("R2 address 7 zero", rdata, 0);
    put(1'b1, CTL, 16'h0000);

    // R3 directed latency: old value one cycle after the write, product next
    put(1'b1, ALO, 16'h0003);
    put(1'b1, AHI, 16'h0005);
    put(1'b0, BLO, 16'h0);
    check("R3 B-low before update", rdata, 16'h0000);
    put(1'b0, BLO, 16'h0);
    check("R3 B-low at latency", rdata, 16'h000F);
    put(1'b1, ALO, 16'hFFFF);
    put(1'b1, AHI, 16'hFFFF);
    idle(1);
    rd32(BLO, v);
    check("R3 max product", v, 32'hFFFE_0001);

    // R3 random products
    for (int i = 0; i < 24; i++) begin
      a = 16'($urandom); b = 16'($urandom);
      put(1'b1, ALO, a);
      put(1'b1, AHI, b);
      idle(1);
      rd32(BLO, v);
      check("R3 random product", v, 32'(a) * 32'(b));
    end

    // R4/R5 accumulate with preload
    put(1'b1, CTL, 16'h0040);
    acc = $urandom;
    put(1'b1, CLO, acc[15:0]);
    put(1'b1, CHI, acc[31:16]);
    rd32(CLO, v);
    check("R5 preload", v, acc);
    a = 16'h0007; b = 16'h0009;
    put(1'b1, ALO, a);
    put(1'b1, AHI, b);
    put(1'b0, CLO, 16'h0);
    put(1'b0, CLO, 16'h0);
    check("R4 C-low before update", rdata, acc[15:0]);
    acc = acc + 32'(a) * 32'(b);
    put(1'b0, CLO, 16'h0);
    check("R4 C-low at latency", rdata, acc[15:0]);
    for (int i = 0; i < 10; i++) begin
      a = 16'($urandom); b = 16'($urandom);
      put(1'b1, ALO, a);
      put(1'b1, AHI, b);
      acc = acc + 32'(a) * 32'(b);
    end
    idle(2);
    rd32(CLO, v);
    check("R4 accumulated sum", v, acc);
    rd32(BLO, v);
    check("R4 B holds last product", v, 32'(a) * 32'(b));
    a = 16'($urandom); b = 16'($urandom); b2 = 16'($urandom);
    put(1'b1, ALO, a);
    put(1'b1, AHI, b);
    put(1'b1, AHI, b2);
    acc = acc + 32'(a) * 32'(b) + 32'(a) * 32'(b2);
    idle(2);
    rd32(CLO, v);
    check("R4 back-to-back accumulate", v, acc);

    // R6 R7 R8 R10 directed divisions
    run_div(32'd1000, 32'd7, 8'hC0, "small");
    run_div(32'd5, 32'd9, 8'hC0, "dividend below divisor");
    run_div(32'hFFFF_FFFF, 32'd1, 8'h80, "divisor one irq");
    run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hC0, "equal max");
    run_div(32'hDEAD_BEEF, 32'h0001_0000, 8'h80, "power of two irq");
    run_div(32'h1234_5678, 32'd0, 8'hC0, "divide by zero");
    run_div(32'h0, 32'd0, 8'h80, "zero by zero irq");
    for (int i = 0; i < 24; i++) begin
      n = $urandom;
      d = (i % 3 == 0) ? ($urandom & 32'h0000_FFFF) : $urandom >> (i % 17);
      run_div(n, d, (i % 2 == 0) ? 8'hC0 : 8'h80, "random");
    end

    // R9 writes during a division are ignored
    n = 32'h8765_4321; d = 32'h0000_1234;
    put(1'b1, CTL, 16'h00C0);
    put(1'b1, ALO, n[15:0]);  put(1'b1, AHI, n[31:16]);
    put(1'b1, BLO, d[15:0]);  put(1'b1, BHI, d[31:16]);
    put(1'b1, CTL, 16'h00C1);
    put(1'b1, ALO, 16'hAAAA);
    put(1'b1, BLO, 16'h5555);
    put(1'b1, CHI, 16'h7777);
    put(1'b1, CTL, 16'h0000);
    put(1'b1, CTL, 16'h00C1);
    idle(20);
    rd32(ALO, v);
    check("R9 quotient unaffected", v, exp_quo(n, d));
    rd32(CLO, v);
    check("R9 remainder unaffected", v, exp_rem(n, d));
    rd32(BLO, v);
    check("R9 divisor unaffected", v, d);
    put(1'b0, CTL, 16'h0);
    check("R9 mode unaffected and idle", rdata, 16'h00C0);

    // R11 A-high write in divide mode starts no multiply
    oldb = d;
    put(1'b1, ALO, 16'h0011);
    put(1'b1, AHI, 16'h0022);
    idle(3);
    rd32(BLO, v);
    check("R11 B unchanged", v, oldb);
    put(1'b0, AHI, 16'h0);
    check("R11 A-high stored", rdata, 16'h0022);

    // R10 no interrupt in the multiply modes
    put(1'b1, CTL, 16'h0000);
    put(1'b1, AHI, 16'h0003);
    begin
      int irqs = 0;
      for (int i = 0; i < 4; i++) begin
        put(1'b0, NUL, 16'h0);
        if (irq) irqs++;
      end
      check("R10 no irq in multiply", irqs, 0);
    end

    summary();
  end
endmodule